// File: doc/BRIEF.md
# External Asynchronous Bus Sequencer

This block takes single-word read and write requests from an internal valid/ready port. It runs each one as one cycle on an asynchronous parallel bus with a 9-bit word address, a 16-bit data bus and six active-low chip selects. It also drives active-low read strobe (OE), write strobe (WE) and address-valid (ADV) lines. The request's physical byte address picks the chip select through a fixed window map. Bits [9:1] of that address become the bus word address. An address that falls in no window gets an error response and causes no bus activity.

Every phase length comes from a timing bank that holds one set of 5-bit fields per chip select. A small write port loads the bank. The fields cover read and write strobe wait counts, separate first-access latencies, the pre-strobe read segment, ADV-to-OE spacing, a write hold that keeps CS low, an address-hold option and turnaround recovery. The sequencer remembers whether the last completed access was a read and which select it used. It inserts recovery idle cycles when the next access needs them.

Top module: `xbus_ctrl`

## Requirements
- R1: Decode selects CS0 for [0x1a800000,0x1b000000), CS1 for [0x1b000000,0x1b800000), CS2 for [0x1b800000,0x1c000000), CS5 for [0x1c000000,0x1c800000), CS4 for [0x1c800000,0x1d000000) and CS3 for [0x1d000000,0x25000000). Chip select k is bit k of `bus_cs_no`, at most one is low, and `bus_addr_o` carries request address bits [9:1] while CS is low.
- R2: A request outside every window produces `rsp_valid_o` with `rsp_err_o`=1 in the cycle after acceptance, with no chip select asserted.
- R3: A read keeps CS low without OE for max(1+addr_hold, rd_hold, adv_oe) cycles before OE asserts. ADV is low only in the first CS cycle.
- R4: OE stays low for rd_wait+1 cycles, or rd_delta+1 when `req_first_i` is set. The response data is the bus value sampled in the last OE cycle.
- R5: A write asserts WE after 1+addr_hold CS cycles, for wr_wait+1 cycles, or wr_delta+1 when `req_first_i` is set.
- R6: After WE deasserts, CS stays low for wr_hold+1 more cycles. Write data is driven (`bus_dq_oe_o`=1, `bus_dq_o`=write data) from the first WE cycle through the last hold cycle.
- R7: After a read, max(recov,1) idle cycles with all CS high precede the next access when it targets another select or is a write to the same one. recov comes from the read's select. Read-to-read on the same select and any access after a write get none.
- R8: `bus_dq_oe_o` is never 1 while OE is low.
- R9: `req_ready_o` is high only when no access is in progress. Each accepted request yields exactly one response pulse, and the end of the access frees the port.
- R10: Configuration writes set the field chosen by code (0 rd_wait, 1 wr_wait, 2 rd_delta, 3 wr_delta, 4 rd_hold, 5 wr_hold, 6 adv_oe, 7 recov, 8 addr_hold in bit 0) of the select given by `cfg_cs_i` only. Reset clears every field.
- R11: After reset all chip selects and strobes are high, `bus_dq_oe_o` is 0, `req_ready_o` is 1 and `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing bank write strobe |
| cfg_cs_i | input | 3 | Chip select whose timing is written |
| cfg_field_i | input | 4 | Field code |
| cfg_wdata_i | input | 5 | Field value |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_first_i | input | 1 | First access to a page, use delta latency |
| req_addr_i | input | 32 | Physical byte address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Address decoded to no window |
| rsp_rdata_o | output | 16 | Read data |
| bus_addr_o | output | 9 | Bus word address |
| bus_cs_no | output | 6 | Chip selects, active low |
| bus_oe_no | output | 1 | Read strobe, active low |
| bus_we_no | output | 1 | Write strobe, active low |
| bus_adv_no | output | 1 | Address valid, active low |
| bus_dq_o | output | 16 | Write data out |
| bus_dq_oe_o | output | 1 | Data bus output enable |
| bus_dq_i | input | 16 | Data bus in |

## Verification
The assertions assume that the timing bank is not rewritten while an access runs, since the sequencer snapshots a select's fields only at acceptance. They also assume that `req_*` inputs stay steady while valid is high. The bench writes every configuration value before issuing requests and holds each request from its set-up edge until acceptance. It also changes the bus data input on every OE cycle, so a capture one cycle early or late returns a different word.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int NCS = 6;
  localparam int CSW = $clog2(NCS);
  localparam int TW  = 5;
  localparam int AW  = 9;
  localparam int DW  = 16;
  localparam int PAW = 32;
  localparam int FW  = 4;

  typedef struct packed {
    logic [TW-1:0] rd_wait;
    logic [TW-1:0] wr_wait;
    logic [TW-1:0] rd_delta;
    logic [TW-1:0] wr_delta;
    logic [TW-1:0] rd_hold;
    logic [TW-1:0] wr_hold;
    logic [TW-1:0] adv_oe;
    logic [TW-1:0] recov;
    logic          addr_hold;
  } cs_timing_t;

  typedef enum logic [FW-1:0] {
    F_RD_WAIT  = 4'd0,
    F_WR_WAIT  = 4'd1,
    F_RD_DELTA = 4'd2,
    F_WR_DELTA = 4'd3,
    F_RD_HOLD  = 4'd4,
    F_WR_HOLD  = 4'd5,
    F_ADV_OE   = 4'd6,
    F_RECOV    = 4'd7,
    F_ADDR_HLD = 4'd8
  } cfg_field_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECOV, ST_SETUP, ST_STROBE, ST_WHOLD
  } bus_state_e;

  function automatic logic [PAW-1:0] win_base(int unsigned i);
    case (i)
      0:       return 32'h1a80_0000;
      1:       return 32'h1b00_0000;
      2:       return 32'h1b80_0000;
      3:       return 32'h1d00_0000;
      4:       return 32'h1c80_0000;
      default: return 32'h1c00_0000;
    endcase
  endfunction

  function automatic logic [PAW-1:0] win_size(int unsigned i);
    return (i == 3) ? 32'h0800_0000 : 32'h0080_0000;
  endfunction
endpackage

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
  import xbus_pkg::*;
#(
  parameter int N = NCS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CSW-1:0] sel_i,
  input  logic [FW-1:0]  field_i,
  input  logic [TW-1:0]  wdata_i,
  output cs_timing_t     cfg_o [N]
);
  for (genvar i = 0; i < N; i++) begin : g_cs
    logic hit;
    assign hit = we_i && (sel_i == CSW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[i] <= '0;
      end else if (hit) begin
        case (cfg_field_e'(field_i))
          F_RD_WAIT:  cfg_o[i].rd_wait   <= wdata_i;
          F_WR_WAIT:  cfg_o[i].wr_wait   <= wdata_i;
          F_RD_DELTA: cfg_o[i].rd_delta  <= wdata_i;
          F_WR_DELTA: cfg_o[i].wr_delta  <= wdata_i;
          F_RD_HOLD:  cfg_o[i].rd_hold   <= wdata_i;
          F_WR_HOLD:  cfg_o[i].wr_hold   <= wdata_i;
          F_ADV_OE:   cfg_o[i].adv_oe    <= wdata_i;
          F_RECOV:    cfg_o[i].recov     <= wdata_i;
          F_ADDR_HLD: cfg_o[i].addr_hold <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int N = NCS
) (
  input  logic [PAW-1:0] addr_i,
  output logic           hit_o,
  output logic [CSW-1:0] idx_o
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_win
    logic [PAW:0] lo, hi;
    assign lo = {1'b0, win_base(i)};
    assign hi = lo + {1'b0, win_size(i)};
    assign match[i] = ({1'b0, addr_i} >= lo) && ({1'b0, addr_i} < hi);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = CSW'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int N = NCS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  cs_timing_t     cfg_i [N],
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_write_i,
  input  logic           req_first_i,
  input  logic [AW-1:0]  req_waddr_i,
  input  logic [DW-1:0]  req_wdata_i,
  input  logic           hit_i,
  input  logic [CSW-1:0] idx_i,
  output logic           rsp_valid_o,
  output logic           rsp_err_o,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [N-1:0]   bus_cs_no,
  output logic           bus_oe_no,
  output logic           bus_we_no,
  output logic           bus_adv_no,
  output logic [DW-1:0]  bus_dq_o,
  output logic           bus_dq_oe_o,
  input  logic [DW-1:0]  bus_dq_i
);
  bus_state_e     state;
  logic [TW-1:0]  cnt;
  logic [CSW-1:0] cur_cs, last_cs;
  logic           cur_write, cur_first, last_rd, adv_q;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;
  cs_timing_t     cur_cfg;

  // cycles with CS low before the strobe, minus one
  function automatic logic [TW-1:0] setup_m1(cs_timing_t c, logic wr);
    logic [TW-1:0] len;
    len = c.addr_hold ? TW'(2) : TW'(1);
    if (!wr) begin
      if (c.rd_hold > len) len = c.rd_hold;
      if (c.adv_oe  > len) len = c.adv_oe;
    end
    return len - TW'(1);
  endfunction

  function automatic logic [TW-1:0] strobe_m1(cs_timing_t c, logic wr, logic first);
    if (wr) return first ? c.wr_delta : c.wr_wait;
    return first ? c.rd_delta : c.rd_wait;
  endfunction

  logic          accept, need_rec;
  logic [TW-1:0] prev_recov;

  assign accept     = req_valid_i && req_ready_o;
  assign prev_recov = cfg_i[last_cs].recov;
  assign need_rec   = last_rd && ((idx_i != last_cs) || req_write_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      cur_cs      <= '0;
      last_cs     <= '0;
      cur_write   <= 1'b0;
      cur_first   <= 1'b0;
      last_rd     <= 1'b0;
      adv_q       <= 1'b0;
      cur_addr    <= '0;
      cur_wdata   <= '0;
      cur_cfg     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      adv_q       <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (!hit_i) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b1;
          end else begin
            cur_cs    <= idx_i;
            cur_write <= req_write_i;
            cur_first <= req_first_i;
            cur_addr  <= req_waddr_i;
            cur_wdata <= req_wdata_i;
            cur_cfg   <= cfg_i[idx_i];
            if (need_rec) begin
              state <= ST_RECOV;
              cnt   <= (prev_recov == '0) ? '0 : prev_recov - TW'(1);
            end else begin
              state <= ST_SETUP;
              adv_q <= 1'b1;
              cnt   <= setup_m1(cfg_i[idx_i], req_write_i);
            end
          end
        end
        ST_RECOV: begin
          if (cnt == '0) begin
            state <= ST_SETUP;
            adv_q <= 1'b1;
            cnt   <= setup_m1(cur_cfg, cur_write);
          end else cnt <= cnt - TW'(1);
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= strobe_m1(cur_cfg, cur_write, cur_first);
          end else cnt <= cnt - TW'(1);
        end
        ST_STROBE: begin
          if (cnt != '0) cnt <= cnt - TW'(1);
          else if (cur_write) begin
            state <= ST_WHOLD;
            cnt   <= cur_cfg.wr_hold;
          end else begin
            state       <= ST_IDLE;
            rsp_rdata_o <= bus_dq_i;
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b0;
            last_rd     <= 1'b1;
            last_cs     <= cur_cs;
          end
        end
        ST_WHOLD: begin
          if (cnt != '0) cnt <= cnt - TW'(1);
          else begin
            state       <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b0;
            last_rd     <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic cs_active;
  assign cs_active   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_WHOLD);
  assign req_ready_o = (state == ST_IDLE);
  assign bus_cs_no   = cs_active ? ~(N'(1) << cur_cs) : '1;
  assign bus_adv_no  = !((state == ST_SETUP) && adv_q);
  assign bus_oe_no   = !((state == ST_STROBE) && !cur_write);
  assign bus_we_no   = !((state == ST_STROBE) && cur_write);
  assign bus_dq_oe_o = cur_write && ((state == ST_STROBE) || (state == ST_WHOLD));
  assign bus_dq_o    = cur_wdata;
  assign bus_addr_o  = cur_addr;

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));
  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_i) |=> (rsp_valid_o && rsp_err_o && (&bus_cs_no)));
  assert_adv_in_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_adv_no |-> (!(&bus_cs_no) && bus_oe_no && bus_we_no));
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_oe_no && !bus_we_no));
  assert_rec_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RECOV) |-> (&bus_cs_no && !bus_dq_oe_o));
  assert_no_contention_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_no |-> !bus_dq_oe_o);
  assert_busy_after_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_i) |=> !req_ready_o);
  assert_rsp_frees_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CSW-1:0]      cfg_cs_i,
  input  logic [FW-1:0]       cfg_field_i,
  input  logic [TW-1:0]       cfg_wdata_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic                req_first_i,
  input  logic [PAW-1:0]      req_addr_i,
  input  logic [DW-1:0]       req_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DW-1:0]       rsp_rdata_o,
  output logic [AW-1:0]       bus_addr_o,
  output logic [NCS-1:0]      bus_cs_no,
  output logic                bus_oe_no,
  output logic                bus_we_no,
  output logic                bus_adv_no,
  output logic [DW-1:0]       bus_dq_o,
  output logic                bus_dq_oe_o,
  input  logic [DW-1:0]       bus_dq_i
);
  cs_timing_t     cfg [NCS];
  logic           hit;
  logic [CSW-1:0] idx;

  xbus_cfg_bank #(.N(NCS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_cs_i),
    .field_i (cfg_field_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  xbus_decode #(.N(NCS)) u_dec (
    .addr_i (req_addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  xbus_seq #(.N(NCS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_first_i (req_first_i),
    .req_waddr_i (req_addr_i[AW:1]),
    .req_wdata_i (req_wdata_i),
    .hit_i       (hit),
    .idx_i       (idx),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .bus_addr_o  (bus_addr_o),
    .bus_cs_no   (bus_cs_no),
    .bus_oe_no   (bus_oe_no),
    .bus_we_no   (bus_we_no),
    .bus_adv_no  (bus_adv_no),
    .bus_dq_o    (bus_dq_o),
    .bus_dq_oe_o (bus_dq_oe_o),
    .bus_dq_i    (bus_dq_i)
  );
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [3:0]  cfg_field = '0;
  logic [4:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_first = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [8:0]  bus_addr;
  logic [5:0]  bus_cs_n;
  logic        bus_oe_n, bus_we_n, bus_adv_n, bus_dq_oe;
  logic [15:0] bus_dq_out;
  logic [15:0] bus_dq_in = '0;

  int total = 0;
  int bad = 0;
  int m_pre, m_cs, m_oe_first, m_oe, m_we_first, m_we, m_hold, m_dqoe;
  int m_dq_bad, m_adv, m_adv_bad, m_addr_bad, m_idx, m_rdy_bad, m_drive_bad, m_lat;
  logic        m_err;
  logic [15:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_cs_i(cfg_cs), .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_first_i(req_first), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_cs_no(bus_cs_n), .bus_oe_no(bus_oe_n), .bus_we_no(bus_we_n),
    .bus_adv_no(bus_adv_n), .bus_dq_o(bus_dq_out), .bus_dq_oe_o(bus_dq_oe), .bus_dq_i(bus_dq_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_set(input int cs, input int field, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_field = 4'(field); cfg_wdata = 5'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [15:0] wd,
                        input bit first, input logic [15:0] base);
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_first = first;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    m_pre = 0; m_cs = 0; m_oe_first = -1; m_oe = 0; m_we_first = -1; m_we = 0; m_hold = 0;
    m_dqoe = 0; m_dq_bad = 0; m_adv = 0; m_adv_bad = 0; m_addr_bad = 0; m_idx = -1;
    m_rdy_bad = 0; m_drive_bad = 0; m_lat = 0; m_err = 1'bx; m_rdata = 'x;
    for (int k = 0; k < 400; k++) begin
      if (rsp_valid) begin
        m_err = rsp_err; m_rdata = rsp_rdata;
        break;
      end
      m_lat++;
      if (req_ready) m_rdy_bad++;
      if (bus_dq_oe && !bus_oe_n) m_drive_bad++;
      if (&bus_cs_n) begin
        if (!seen) m_pre++;
      end else begin
        seen = 1;
        for (int j = 0; j < 6; j++) if (!bus_cs_n[j]) m_idx = j;
        if (!bus_adv_n) begin
          m_adv++;
          if (m_cs != 0) m_adv_bad++;
        end
        if (!bus_oe_n) begin
          if (m_oe == 0) m_oe_first = m_cs;
          bus_dq_in = base + 16'(m_oe);
          m_oe++;
        end
        if (!bus_we_n) begin
          if (m_we == 0) m_we_first = m_cs;
          m_we++;
        end else if (m_we > 0) m_hold++;
        if (bus_dq_oe) begin
          m_dqoe++;
          if (bus_dq_out != wd) m_dq_bad++;
        end
        if (bus_addr != addr[9:1]) m_addr_bad++;
        m_cs++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 cs idle", int'(bus_cs_n), 63);
    chk("R11 strobes idle", int'({bus_oe_n, bus_we_n, bus_adv_n}), 7);
    chk("R11 dq_oe", int'(bus_dq_oe), 0);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 rsp", int'(rsp_valid), 0);
  endtask

  task automatic t_config;
    // field codes: 0 rdw,1 wrw,2 rdd,3 wrd,4 rdh,5 wrh,6 adv_oe,7 recov,8 ahold  (R10)
    cfg_set(0, 4, 3); cfg_set(0, 6, 2); cfg_set(0, 0, 2); cfg_set(0, 2, 5); cfg_set(0, 7, 0);
    cfg_set(1, 8, 1); cfg_set(1, 0, 1); cfg_set(1, 1, 3); cfg_set(1, 3, 6);
    cfg_set(1, 5, 2); cfg_set(1, 7, 4);
    cfg_set(2, 6, 4); cfg_set(2, 4, 1); cfg_set(2, 0, 0); cfg_set(2, 7, 2);
  endtask

  task automatic t_read_basic;
    access(0, 32'h1a80_0010, 16'h0, 0, 16'h1000);
    chk("R1 cs0 idx", m_idx, 0);
    chk("R1 addr", m_addr_bad, 0);
    chk("R7 no rec first", m_pre, 0);
    chk("R3 pre-oe max(rd_hold,adv_oe)", m_oe_first, 3);
    chk("R3 adv once", m_adv, 1);
    chk("R3 adv first cycle", m_adv_bad, 0);
    chk("R4 oe len", m_oe, 3);
    chk("R4 rdata last oe", int'(m_rdata), 16'h1002);
    chk("R4 err", int'(m_err), 0);
    chk("R9 busy", m_rdy_bad, 0);
    chk("R10 cs0 fields via cs len", m_cs, 6);
  endtask

  task automatic t_read_first;
    access(0, 32'h1a80_0020, 16'h0, 1, 16'h2000);
    chk("R7 rd-rd same cs", m_pre, 0);
    chk("R4 delta len", m_oe, 6);
    chk("R4 delta rdata", int'(m_rdata), 16'h2005);
  endtask

  task automatic t_read_ahold;
    access(0, 32'h1b00_0100, 16'h0, 0, 16'h3000);
    chk("R1 cs1 idx", m_idx, 1);
    chk("R7 rec min one", m_pre, 1);
    chk("R3 addr hold pre-oe", m_oe_first, 2);
    chk("R4 oe cs1", m_oe, 2);
    chk("R4 rdata cs1", int'(m_rdata), 16'h3001);
  endtask

  task automatic t_write;
    access(1, 32'h1b00_0102, 16'hbeef, 0, 16'h0);
    chk("R7 rd-wr same cs rec", m_pre, 4);
    chk("R5 we start", m_we_first, 2);
    chk("R5 we len", m_we, 4);
    chk("R6 hold len", m_hold, 3);
    chk("R6 dq drive len", m_dqoe, 7);
    chk("R6 dq value", m_dq_bad, 0);
    chk("R5 no oe", m_oe, 0);
    chk("R9 busy wr", m_rdy_bad, 0);
    access(1, 32'h1b00_0104, 16'h1234, 1, 16'h0);
    chk("R7 after write none", m_pre, 0);
    chk("R5 wr delta len", m_we, 7);
    chk("R6 hold len2", m_hold, 3);
  endtask

  task automatic t_read_cs2;
    access(0, 32'h1b80_0002, 16'h0, 0, 16'h4000);
    chk("R7 wr-rd none", m_pre, 0);
    chk("R3 adv_oe spacing", m_oe_first, 4);
    chk("R4 zero wait", m_oe, 1);
    chk("R4 rdata cs2", int'(m_rdata), 16'h4000);
    access(0, 32'h1b80_0004, 16'h0, 0, 16'h4100);
    chk("R7 rd-rd same cs2", m_pre, 0);
  endtask

  task automatic t_error;
    access(0, 32'h1a7f_fffe, 16'h0, 0, 16'h0);
    chk("R2 err low", int'(m_err), 1);
    chk("R2 immediate", m_lat, 0);
    access(1, 32'h2500_0000, 16'h5555, 0, 16'h0);
    chk("R2 err high", int'(m_err), 1);
    chk("R2 immediate high", m_lat, 0);
    access(0, 32'h1b00_0000, 16'h0, 0, 16'h0);
    chk("R7 rec from cs2 after err", m_pre, 2);
    chk("R2 ok resp", int'(m_err), 0);
  endtask

  task automatic t_sweep;
    logic [31:0] a [10] = '{32'h1a80_0000, 32'h1aff_fffe, 32'h1b00_0000, 32'h1bff_fffe,
                            32'h1c00_0000, 32'h1c7f_fffe, 32'h1c80_0000, 32'h1cff_fffe,
                            32'h1d00_0000, 32'h24ff_fffe};
    int e [10] = '{0, 0, 1, 2, 5, 5, 4, 4, 3, 3};
    for (int i = 0; i < 10; i++) begin
      access(0, a[i], 16'h0, 0, 16'h0);
      chk($sformatf("R1 window %0d", i), m_idx, e[i]);
      chk($sformatf("R8 contention %0d", i), m_drive_bad, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_read_basic();
    t_read_first();
    t_read_ahold();
    t_write();
    chk("R8 write drive", m_drive_bad, 0);
    t_read_cs2();
    t_error();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule